// File: doc/BRIEF.md
# Multi-mode page table walker

This block turns a virtual address into a 32-bit page-aligned physical address. It reads page-table entries one at a time through a plain 32-bit memory read port. A two-bit mode picks the table format:

- `0` is flat. Paging is off, so the address passes straight through.
- `1` is classic two-level 32-bit paging with 4-byte entries.
- `2` is three-level extended-address paging with 8-byte entries, of which only the low word is read.
- `3` is four-level long mode, which also checks that the address is canonical.

The root table pointer, the large-page enable and an address-line mask are captured with each request. The mask is applied to every table fetch.

A request is taken when `req_valid` and `req_ready` are both high. The walker then works on that one translation only, and `req_ready` stays low until the answer has been given. Each answer is a single-cycle pulse on `rsp_valid`, carrying either the page address or a fault.

The controller has four states:

- `ST_IDLE` accepts a request. It moves to `ST_REPLY` for flat mode or a non-canonical long-mode address. In every other case it moves to `ST_ISSUE` at the first table level of the mode.
- `ST_ISSUE` drives the fetch and moves to `ST_WAIT` once `mem_req_ready` is seen.
- `ST_WAIT` takes the entry when `mem_rsp_valid` arrives. It moves to `ST_REPLY` on a clear present bit, on a large-page leaf or at the last level. Otherwise it returns to `ST_ISSUE` for the next level.
- `ST_REPLY` raises the response and always returns to `ST_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when no translation is in progress. It falls in the cycle after a request is accepted. `rsp_valid` is high for exactly one cycle per request, and `req_ready` is high again in the next cycle.
- R2: In flat mode (`req_mode`=0) the walker makes no memory read. It answers in the cycle after acceptance with `(vaddr[31:0] & addr_mask)` with bits [11:0] cleared, and without a fault.
- R3: In classic mode (`req_mode`=1), the directory entry is read at `{root[31:12],12'b0} + vaddr[31:22]*4`. The table entry is read at `{dir[31:12],12'b0} + vaddr[21:12]*4`. A 4 KB result is `{pte[31:12],12'b0}`.
- R4: In classic mode, a directory entry with bit 7 set gives a 4 MB page only if `large_en` is high. The result is then `{dir[31:22],22'b0} + vaddr[21:12]*4096`, and no table entry is read. Otherwise the walk continues to the table level.
- R5: In extended mode (`req_mode`=2), the first entry is read at `{root[31:5],5'b0} + vaddr[31:30]*8`. The directory and table entries are read at their parent's `[31:12]` base plus `vaddr[29:21]*8` and `vaddr[20:12]*8` respectively. Virtual bits above 31 have no effect.
- R6: In extended and long modes, a directory entry with bit 7 set gives a 2 MB page whatever `large_en` is. The result is `{dir[31:21],21'b0} + vaddr[20:12]*4096`. The final frame in these modes is not masked.
- R7: In long mode (`req_mode`=3), if `vaddr[63:47]` are not all equal, the walker faults in the cycle after acceptance with no memory read. Otherwise it reads `{root[31:12],12'b0} + vaddr[47:39]*8`, then `{e4[31:12],12'b0} + vaddr[38:30]*8`, then continues as in R5.
- R8: An entry with bit 0 clear at any level ends the walk with `rsp_fault`=1 and `rsp_paddr`=0, and no further entry is read.
- R9: Every fetch address is ANDed with `addr_mask` before it is issued. In flat and classic modes the final frame is also ANDed with `addr_mask`.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged.
- R11: Bits [11:0] of `rsp_paddr` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address |
| req_mode | input | 2 | 0 flat, 1 classic, 2 extended, 3 long |
| root_base | input | 32 | Root table pointer |
| large_en | input | 1 | Allows 4 MB pages in classic mode |
| addr_mask | input | 32 | Address-line mask |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 32 | Page-aligned physical address, zero on a fault |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 32 | Entry fetch address |
| mem_rsp_valid | input | 1 | Fetched entry is valid |
| mem_rsp_data | input | 32 | Fetched entry |

## Verification
The bench targets the places where the three table formats differ:

- **Classic large pages.** The bench sends a classic directory entry with bit 7 set, both with and without `large_en`. A walker that ignored the enable would skip the table read and return a 4 MB frame.
- **Extended first level.** The bench uses a root pointer whose bits [11:5] are non-zero. A walker that cleared twelve root bits would fetch the wrong first entry.
- **Extended large pages.** A 2 MB entry is sent with `large_en` low and with a mask that clears a frame bit. A walker that consulted the enable, or masked the extended frame, would return a different address.
- **Long mode.** Non-canonical addresses must fault with no read, and a missing present bit must stop the walk at that level. Each fetched address is logged against the expected list, so a wrong index slice or a missing mask shows up as a wrong address or a wrong read count.
- **Memory stalls.** A slow memory holds off `mem_req_ready`, to expose a request that moves before it is accepted.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int VA_W      = 64;
    localparam int PA_W      = 32;
    localparam int PRES_BIT  = 0;
    localparam int LARGE_BIT = 7;

    typedef enum logic [1:0] {
        MODE_FLAT    = 2'd0,
        MODE_CLASSIC = 2'd1,
        MODE_EXT3    = 2'd2,
        MODE_LONG    = 2'd3
    } xlat_mode_e;

    typedef enum logic [1:0] {
        LV_TOP = 2'd0,
        LV_MID = 2'd1,
        LV_DIR = 2'd2,
        LV_TBL = 2'd3
    } walk_level_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_REPLY = 2'd3
    } walk_state_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr
    import pt_walker_pkg::*;
(
    input  xlat_mode_e  mode,
    input  walk_level_e level,
    input  logic [31:5] ptr,
    input  logic [47:12] va,
    input  logic [PA_W-1:0] mask,
    output logic [PA_W-1:0] addr
);

    logic [PA_W-1:0] page_base;
    logic [PA_W-1:0] raw;

    assign page_base = {ptr[31:12], 12'd0};

    always_comb begin
        unique case (level)
            LV_TOP: raw = page_base + {20'd0, va[47:39], 3'd0};
            LV_MID: begin
                if (mode == MODE_LONG)
                    raw = page_base + {20'd0, va[38:30], 3'd0};
                else
                    raw = {ptr[31:5], 5'd0} + {27'd0, va[31:30], 3'd0};
            end
            LV_DIR: begin
                if (mode == MODE_CLASSIC)
                    raw = page_base + {20'd0, va[31:22], 2'd0};
                else
                    raw = page_base + {20'd0, va[29:21], 3'd0};
            end
            LV_TBL: begin
                if (mode == MODE_CLASSIC)
                    raw = page_base + {20'd0, va[21:12], 2'd0};
                else
                    raw = page_base + {20'd0, va[20:12], 3'd0};
            end
            default: raw = '0;
        endcase
    end

    assign addr = raw & mask;

endmodule

// File: rtl/pt_result.sv
module pt_result
    import pt_walker_pkg::*;
(
    input  pg_size_e        size,
    input  logic [31:12]    frame,
    input  logic [21:12]    va,
    input  logic [PA_W-1:0] mask,
    input  logic            mask_en,
    output logic [PA_W-1:0] paddr
);

    logic [PA_W-1:0] base;
    logic [PA_W-1:0] offs;

    always_comb begin
        unique case (size)
            PG_4K: begin
                base = {frame, 12'd0};
                offs = '0;
            end
            PG_2M: begin
                base = {frame[31:21], 21'd0};
                offs = {11'd0, va[20:12], 12'd0};
            end
            PG_4M: begin
                base = {frame[31:22], 22'd0};
                offs = {10'd0, va[21:12], 12'd0};
            end
            default: begin
                base = '0;
                offs = '0;
            end
        endcase
        if (mask_en)
            base = base & mask;
        paddr = base + offs;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_mode,
    input  logic [PA_W-1:0] root_base,
    input  logic            large_en,
    input  logic [PA_W-1:0] addr_mask,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data
);

    walk_state_e  state_q, state_d;
    walk_level_e  level_q, level_d;
    xlat_mode_e   mode_q,  mode_d;
    pg_size_e     size_q,  size_d;
    logic [47:12] va_q,    va_d;
    logic [31:5]  ptr_q,   ptr_d;
    logic [31:12] frame_q, frame_d;
    logic [PA_W-1:0] mask_q, mask_d;
    logic         large_q, large_d;
    logic         fault_q, fault_d;

    logic            canonical;
    logic            mask_en;
    logic            leaf_large;
    logic [PA_W-1:0] fetch_addr;
    logic [PA_W-1:0] result;
    logic            unused_bits;

    assign canonical   = (&req_vaddr[63:47]) | ~(|req_vaddr[63:47]);
    assign mask_en     = (mode_q == MODE_FLAT) || (mode_q == MODE_CLASSIC);
    assign leaf_large  = mem_rsp_data[LARGE_BIT] &&
                         ((mode_q != MODE_CLASSIC) || large_q);
    assign unused_bits = ^{req_vaddr[11:0], mem_rsp_data[4:1]};

    pt_entry_addr u_addr (
        .mode  (mode_q),
        .level (level_q),
        .ptr   (ptr_q),
        .va    (va_q),
        .mask  (mask_q),
        .addr  (fetch_addr)
    );

    pt_result u_result (
        .size    (size_q),
        .frame   (frame_q),
        .va      (va_q[21:12]),
        .mask    (mask_q),
        .mask_en (mask_en),
        .paddr   (result)
    );

    always_comb begin
        state_d = state_q;
        level_d = level_q;
        mode_d  = mode_q;
        size_d  = size_q;
        va_d    = va_q;
        ptr_d   = ptr_q;
        frame_d = frame_q;
        mask_d  = mask_q;
        large_d = large_q;
        fault_d = fault_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    mode_d  = xlat_mode_e'(req_mode);
                    va_d    = req_vaddr[47:12];
                    ptr_d   = root_base[31:5];
                    frame_d = req_vaddr[31:12];
                    mask_d  = addr_mask;
                    large_d = large_en;
                    size_d  = PG_4K;
                    fault_d = 1'b0;
                    unique case (xlat_mode_e'(req_mode))
                        MODE_FLAT:    state_d = ST_REPLY;
                        MODE_CLASSIC: begin
                            level_d = LV_DIR;
                            state_d = ST_ISSUE;
                        end
                        MODE_EXT3: begin
                            level_d = LV_MID;
                            state_d = ST_ISSUE;
                        end
                        MODE_LONG: begin
                            if (canonical) begin
                                level_d = LV_TOP;
                                state_d = ST_ISSUE;
                            end else begin
                                fault_d = 1'b1;
                                state_d = ST_REPLY;
                            end
                        end
                        default: state_d = ST_REPLY;
                    endcase
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready)
                    state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    ptr_d   = mem_rsp_data[31:5];
                    frame_d = mem_rsp_data[31:12];
                    if (!mem_rsp_data[PRES_BIT]) begin
                        fault_d = 1'b1;
                        state_d = ST_REPLY;
                    end else begin
                        unique case (level_q)
                            LV_TOP: begin
                                level_d = LV_MID;
                                state_d = ST_ISSUE;
                            end
                            LV_MID: begin
                                level_d = LV_DIR;
                                state_d = ST_ISSUE;
                            end
                            LV_DIR: begin
                                if (leaf_large) begin
                                    size_d  = (mode_q == MODE_CLASSIC) ? PG_4M : PG_2M;
                                    state_d = ST_REPLY;
                                end else begin
                                    level_d = LV_TBL;
                                    state_d = ST_ISSUE;
                                end
                            end
                            LV_TBL: begin
                                size_d  = PG_4K;
                                state_d = ST_REPLY;
                            end
                            default: state_d = ST_REPLY;
                        endcase
                    end
                end
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            level_q <= LV_TOP;
            mode_q  <= MODE_FLAT;
            size_q  <= PG_4K;
            va_q    <= '0;
            ptr_q   <= '0;
            frame_q <= '0;
            mask_q  <= '1;
            large_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            mode_q  <= mode_d;
            size_q  <= size_d;
            va_q    <= va_d;
            ptr_q   <= ptr_d;
            frame_q <= frame_d;
            mask_q  <= mask_d;
            large_q <= large_d;
            fault_q <= fault_d;
        end
    end

    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = (state_q == ST_ISSUE) ? fetch_addr : '0;
        rsp_valid     = (state_q == ST_REPLY);
        rsp_fault     = (state_q == ST_REPLY) && fault_q;
        rsp_paddr     = ((state_q == ST_REPLY) && !fault_q) ? result : '0;
    end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_vaddr,
    input logic [1:0]  req_mode,
    input logic [31:0] addr_mask,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_paddr,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr
);

    logic        accept;
    logic        noncanon;
    logic [31:0] held_mask;
    logic        unused_chk;

    assign accept     = req_valid && req_ready;
    assign noncanon   = !((&req_vaddr[63:47]) || !(|req_vaddr[63:47]));
    assign unused_chk = ^req_vaddr[46:32];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_mask <= '1;
        else if (accept)
            held_mask <= addr_mask;
    end

    // R1
    busy_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    // R1
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R1
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R2
    flat_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == 2'd0) |=>
            (rsp_valid && !rsp_fault &&
             rsp_paddr == ($past(req_vaddr[31:0]) & $past(addr_mask) & 32'hFFFF_F000)));

    // R7
    noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == 2'd3 && noncanon) |=> (rsp_valid && rsp_fault));

    // R8
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'd0));

    // R9
    fetch_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_addr & ~held_mask) == 32'd0));

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11
    page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_paddr[11:0] == 12'd0));

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_mode      (req_mode),
    .addr_mask     (addr_mask),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_vaddr;
    logic [1:0]  req_mode;
    logic [31:0] root_base;
    logic        large_en;
    logic [31:0] addr_mask;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] rd_log [0:7];
    int          rd_n;
    logic        slow;
    logic        gap;
    logic [31:0] held_addr;

    always #10 clk = ~clk;

    pt_walker dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_mode      (req_mode),
        .root_base     (root_base),
        .large_en      (large_en),
        .addr_mask     (addr_mask),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_paddr     (rsp_paddr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    function automatic logic [31:0] peek(input logic [31:0] a);
        if (mem_img.exists(a))
            return mem_img[a];
        return 32'd0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // memory model: accepts one fetch, answers one cycle later
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'd0;
        gap           = 1'b0;
        held_addr     = 32'd0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = peek(held_addr);
                if (rd_n < 8) rd_log[rd_n] = held_addr;
                rd_n++;
            end else if (mem_req_valid) begin
                if (slow && !gap) begin
                    gap = 1'b1;
                end else begin
                    gap           = 1'b0;
                    held_addr     = mem_req_addr;
                    mem_req_ready = 1'b1;
                end
            end
        end
    end

    task automatic translate(input logic [1:0] m, input logic [63:0] va,
                             input logic [31:0] root, input logic le,
                             input logic [31:0] msk,
                             output logic flt, output logic [31:0] pa);
        int n;
        @(negedge clk);
        req_mode  = m;
        req_vaddr = va;
        root_base = root;
        large_en  = le;
        addr_mask = msk;
        req_valid = 1'b1;
        rd_n      = 0;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 100) begin
            check("R1 ready low while busy", req_ready, 1'b0);
            @(negedge clk);
            n++;
        end
        check("R1 response seen", rsp_valid, 1'b1);
        flt = rsp_fault;
        pa  = rsp_paddr;
        @(negedge clk);
        check("R1 ready after response", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic exp_reads(input string tag, input int n,
                             input logic [31:0] a0, input logic [31:0] a1,
                             input logic [31:0] a2, input logic [31:0] a3);
        logic [31:0] e [0:3];
        e[0] = a0; e[1] = a1; e[2] = a2; e[3] = a3;
        check({tag, " read count"}, rd_n, n);
        for (int i = 0; i < n && i < 4; i++)
            check({tag, " read addr"}, rd_log[i], e[i]);
    endtask

    task automatic t_reset();
        check("R1 reset ready", req_ready, 1'b1);
        check("R1 reset idle outputs", {rsp_valid, rsp_fault, mem_req_valid}, 3'b000);
    endtask

    task automatic t_flat();
        logic f; logic [31:0] p;
        translate(2'd0, 64'hDEAD_BEEF_1234_5678, 32'h0000_1000, 1'b1, 32'hFFEF_FFFF, f, p);
        check("R2 flat fault", f, 1'b0);
        check("R2 R9 flat paddr", p, 32'h1224_5000);
        exp_reads("R2 flat", 0, 0, 0, 0, 0);
    endtask

    task automatic t_classic_4k();
        logic f; logic [31:0] p;
        translate(2'd1, 64'h0000_0000_0040_3123, 32'h0000_1ABC, 1'b1, 32'hFFFF_FFFF, f, p);
        check("R3 classic fault", f, 1'b0);
        check("R3 R11 classic paddr", p, 32'h0ABC_D000);
        exp_reads("R3 classic", 2, 32'h1004, 32'h200C, 0, 0);
    endtask

    task automatic t_classic_large();
        logic f; logic [31:0] p;
        translate(2'd1, 64'h0095_5ABC, 32'h0000_1000, 1'b1, 32'hFFFF_FFFF, f, p);
        check("R4 4M paddr", p, 32'h12D5_5000);
        exp_reads("R4 4M", 1, 32'h1008, 0, 0, 0);
        translate(2'd1, 64'h0095_5ABC, 32'h0000_1000, 1'b0, 32'hFFFF_FFFF, f, p);
        check("R4 no enable paddr", p, 32'h0007_7000);
        exp_reads("R4 no enable", 2, 32'h1008, 32'h12C0_0554, 0, 0);
        translate(2'd1, 64'h0095_5ABC, 32'h0000_1000, 1'b1, 32'hFDFF_FFFF, f, p);
        check("R9 4M masked frame", p, 32'h10D5_5000);
    endtask

    task automatic t_classic_mask();
        logic f; logic [31:0] p;
        translate(2'd1, 64'h0040_3123, 32'h0000_1000, 1'b1, 32'hFFFF_EFFF, f, p);
        check("R9 masked fault", f, 1'b0);
        check("R9 masked paddr", p, 32'h0ABC_C000);
        exp_reads("R9 masked", 2, 32'h0004, 32'h200C, 0, 0);
    endtask

    task automatic t_ext3();
        logic f; logic [31:0] p;
        translate(2'd2, 64'h1234_5678_C060_3000, 32'h0000_3037, 1'b0, 32'hFFFF_FFFF, f, p);
        check("R5 ext fault", f, 1'b0);
        check("R5 ext paddr", p, 32'h0ABC_0000);
        exp_reads("R5 ext", 3, 32'h3038, 32'h4018, 32'h5018, 0);
    endtask

    task automatic t_ext3_2m();
        logic f; logic [31:0] p;
        translate(2'd2, 64'h402A_5000, 32'h0000_3037, 1'b0, 32'hDFFF_FFFF, f, p);
        check("R6 2M fault", f, 1'b0);
        check("R6 2M paddr unmasked", p, 32'h346A_5000);
        exp_reads("R6 2M", 2, 32'h3028, 32'h6008, 0, 0);
    endtask

    task automatic t_long();
        logic f; logic [31:0] p;
        slow = 1'b1;
        translate(2'd3, 64'hFFFF_8080_4060_3000, 32'h0000_7ABC, 1'b0, 32'hFFFF_FFFF, f, p);
        slow = 1'b0;
        check("R7 R10 long fault", f, 1'b0);
        check("R7 R10 long paddr", p, 32'h0BAD_0000);
        exp_reads("R7 R10 long", 4, 32'h7808, 32'h8008, 32'h9018, 32'hA018);
    endtask

    task automatic t_noncanon();
        logic f; logic [31:0] p;
        translate(2'd3, 64'h0001_8000_0000_0000, 32'h0000_7000, 1'b0, 32'hFFFF_FFFF, f, p);
        check("R7 noncanon fault", {f, p}, {1'b1, 32'd0});
        exp_reads("R7 noncanon", 0, 0, 0, 0, 0);
        translate(2'd3, 64'h0000_8000_0000_0000, 32'h0000_7000, 1'b0, 32'hFFFF_FFFF, f, p);
        check("R7 bit47 only fault", f, 1'b1);
        exp_reads("R7 bit47 only", 0, 0, 0, 0, 0);
    endtask

    task automatic t_faults();
        logic f; logic [31:0] p;
        translate(2'd1, 64'h0140_0000, 32'h0000_1000, 1'b1, 32'hFFFF_FFFF, f, p);
        check("R8 classic dir absent", {f, p}, {1'b1, 32'd0});
        exp_reads("R8 classic dir", 1, 32'h1014, 0, 0, 0);
        translate(2'd1, 64'h0040_4000, 32'h0000_1000, 1'b1, 32'hFFFF_FFFF, f, p);
        check("R8 classic tbl absent", {f, p}, {1'b1, 32'd0});
        exp_reads("R8 classic tbl", 2, 32'h1004, 32'h2010, 0, 0);
        translate(2'd3, 64'h0, 32'h0000_7000, 1'b0, 32'hFFFF_FFFF, f, p);
        check("R8 long mid absent", {f, p}, {1'b1, 32'd0});
        exp_reads("R8 long mid", 2, 32'h7000, 32'hC000, 0, 0);
        translate(2'd2, 64'hC060_4000, 32'h0000_3037, 1'b0, 32'hFFFF_FFFF, f, p);
        check("R8 ext tbl absent", {f, p}, {1'b1, 32'd0});
        exp_reads("R8 ext tbl", 3, 32'h3038, 32'h4018, 32'h5020, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        req_mode  = 2'd0;
        root_base = '0;
        large_en  = 1'b0;
        addr_mask = '1;
        slow      = 1'b0;
        rd_n      = 0;
        mem_img[32'h1004]     = 32'h0000_2003;
        mem_img[32'h200C]     = 32'h0ABC_D001;
        mem_img[32'h1008]     = 32'h12C0_0083;
        mem_img[32'h12C0_0554] = 32'h0007_7001;
        mem_img[32'h0004]     = 32'h0000_2001;
        mem_img[32'h3038]     = 32'h0000_4001;
        mem_img[32'h4018]     = 32'h0000_5001;
        mem_img[32'h5018]     = 32'h0ABC_0001;
        mem_img[32'h5020]     = 32'h0ABC_0000;
        mem_img[32'h3028]     = 32'h0000_6001;
        mem_img[32'h6008]     = 32'h3460_0081;
        mem_img[32'h7808]     = 32'h0000_8001;
        mem_img[32'h8008]     = 32'h0000_9001;
        mem_img[32'h9018]     = 32'h0000_A001;
        mem_img[32'hA018]     = 32'h0BAD_0001;
        mem_img[32'h7000]     = 32'h0000_C001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flat();
        t_classic_4k();
        t_classic_large();
        t_classic_mask();
        t_ext3();
        t_ext3_2m();
        t_long();
        t_noncanon();
        t_faults();
        report();
        $finish;
    end

endmodule